// File: doc/BRIEF.md
# Minimal 16-bit Stack-Machine Processor Core

This core runs stack-language code directly. Its whole architectural state is a 13-bit program counter, a data stack and a return stack. The data stack is a top-of-stack register in front of 32 stored entries, which gives 33 items. The return stack has 32 entries. The core has no flags, no general registers and no modes. In the run state it fetches one 16-bit instruction per cycle from a word-addressed program memory and executes that instruction in the same cycle.

The three upper bits of an instruction select one of five classes: literal push, jump, conditional jump, call, or a packed ALU word. A single ALU instruction holds an operation select, two stack-pointer adjustments, a return control, a push to the return stack, a copy into the next data slot and a store control. One instruction can therefore implement a whole stack-language word.

Data accesses use a byte address taken from the top item. That address goes either to an 8K-word RAM port or to a separate 8K-word I/O port. Both ports use combinational reads. After reset the controller is in BOOT. The first clock edge after reset moves it to RUN (transition BOOT→RUN), and it then stays in RUN (RUN→RUN) until the next reset.

Top module: `stk16_core`

## Requirements
- R1: While reset (rst_n low) is held and during the single BOOT cycle after it, the fetch address is 0. The instruction at address 0 executes on the second rising edge after reset is released. Reset clears the top item and both stack pointers to 0.
- R2: An instruction with bit 15 set pushes {0, bits 14:0} as the new top item. The old top item moves into the data stack, and the program counter advances by one.
- R3: Bits 15:13 = 000 load the program counter with bits 12:0.
- R4: Bits 15:13 = 001 pop the data stack, so the next item becomes the top item. The branch goes to bits 12:0 only if the popped top item was zero. Otherwise the program counter advances by one.
- R5: Bits 15:13 = 010 push {00, PC+1, 0} (the link in byte form) onto the return stack and load the program counter with bits 12:0.
- R6: Bits 15:13 = 011 form an ALU instruction with these fields. Bit 12 loads the program counter from bits 13:1 of the return-stack top. Bits 11:8 select the operation. Bit 7 writes the old top item into the data slot at the updated pointer. Bit 6 writes the old top item into the return slot at the updated pointer. Bit 5 stores. Bits 3:2 are the return delta and bits 1:0 are the data delta. Deltas are two's complement: 00=0, 01=+1, 10=-2, 11=-1.
- R7: The operation codes 0 T, 1 N, 2 T+N, 3 T&N, 4 T|N, 5 T^N, 6 ~T and 10 T-1 give the new top item, where T is the top item and N is the next item.
- R8: Code 7 (N==T), code 8 (N<T signed) and code 15 (N<T unsigned) return 16'hFFFF when the relation is true and 0 when it is false.
- R9: Code 9 gives N shifted right logically by T[3:0]. Code 13 gives N shifted left by T[3:0].
- R10: Code 11 returns the return-stack top. Code 12 returns the memory word addressed by T. Code 14 returns the data-stack pointer before the instruction, zero-extended.
- R11: Bit 14 of T selects the port: 0 selects RAM and 1 selects I/O. The word index is T[13:1]. A store writes N to exactly one of the two ports.
- R12: A data delta of 10 removes two items from the data stack in one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 13 | Program memory word address |
| imem_data | input | 16 | Instruction at imem_addr |
| ram_addr | output | 13 | RAM word index |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data (combinational) |
| io_addr | output | 13 | I/O word index |
| io_we | output | 1 | I/O write strobe |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data (combinational) |

## Verification
A table of operand pairs runs each ALU operation through a short program: push two literals, apply the operation, store the result to I/O. The pairs are chosen so that a wrong operand order, a wrong shift direction, or a swap between signed and unsigned compare each gives a different stored value. Directed programs then exercise the other classes and fields: a conditional jump with a zero and a nonzero operand, told apart by the I/O word index reached, a call and return whose link is read back through the return-stack operation, a move from the data stack to the return stack and back, RAM and I/O loads and stores, and stack depth after a one-item and a two-item drop.

// File: rtl/stk16_pkg.sv
package stk16_pkg;

    localparam int WORD_W = 16;
    localparam int PC_W   = 13;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PC_W-1:0]   pc_t;

    typedef enum logic [3:0] {
        OP_T    = 4'd0,
        OP_N    = 4'd1,
        OP_ADD  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_INV  = 4'd6,
        OP_EQ   = 4'd7,
        OP_SLT  = 4'd8,
        OP_SHR  = 4'd9,
        OP_DEC  = 4'd10,
        OP_RTOP = 4'd11,
        OP_LOAD = 4'd12,
        OP_SHL  = 4'd13,
        OP_DPTH = 4'd14,
        OP_ULT  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CL_JUMP  = 2'b00,
        CL_CJUMP = 2'b01,
        CL_CALL  = 2'b10,
        CL_ALU   = 2'b11
    } insn_class_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } core_state_e;

endpackage

// File: rtl/stk16_stack.sv
module stk16_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 delta,
    input  logic                       we,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               top,
    output logic [$clog2(DEPTH)-1:0]   ptr
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_d;

    // two-bit signed step, widened to the pointer
    assign ptr_d = ptr_q + {{(PW-2){delta[1]}}, delta};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            if (we) slot_q[ptr_d] <= wdata;
        end
    end

    assign top = slot_q[ptr_q];
    assign ptr = ptr_q;

    AST_WRITE_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> top == $past(wdata)); // R6

endmodule

// File: rtl/stk16_alu.sv
module stk16_alu
    import stk16_pkg::*;
(
    input  alu_op_e op,
    input  word_t   t,
    input  word_t   n,
    input  word_t   r,
    input  word_t   mem_rd,
    input  word_t   depth,
    output word_t   res
);
    always_comb begin
        unique case (op)
            OP_T:    res = t;
            OP_N:    res = n;
            OP_ADD:  res = t + n;
            OP_AND:  res = t & n;
            OP_OR:   res = t | n;
            OP_XOR:  res = t ^ n;
            OP_INV:  res = ~t;
            OP_EQ:   res = {WORD_W{n == t}};
            OP_SLT:  res = {WORD_W{$signed(n) < $signed(t)}};
            OP_SHR:  res = n >> t[3:0];
            OP_DEC:  res = t - 1'b1;
            OP_RTOP: res = r;
            OP_LOAD: res = mem_rd;
            OP_SHL:  res = n << t[3:0];
            OP_DPTH: res = depth;
            OP_ULT:  res = {WORD_W{n < t}};
        endcase
    end
endmodule

// File: rtl/stk16_core.sv
module stk16_core
    import stk16_pkg::*;
#(
    parameter int DS_DEPTH = 32,
    parameter int RS_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [12:0] imem_addr,
    input  logic [15:0] imem_data,
    output logic [12:0] ram_addr,
    output logic        ram_we,
    output logic [15:0] ram_wdata,
    input  logic [15:0] ram_rdata,
    output logic [12:0] io_addr,
    output logic        io_we,
    output logic [15:0] io_wdata,
    input  logic [15:0] io_rdata
);
    localparam int DPW = $clog2(DS_DEPTH);
    localparam int RPW = $clog2(RS_DEPTH);

    core_state_e state_q, state_d;
    pc_t         pc_q, pc_d, pc_inc;
    word_t       tos_q, tos_d;
    word_t       nos, rtop, alu_res, mem_rd;
    word_t       insn;
    logic [DPW-1:0] ds_ptr;
    logic [RPW-1:0] rs_ptr;
    logic [1:0]  ds_delta, rs_delta;
    logic        ds_we, rs_we, st_en, sel_io;
    word_t       rs_wdata;
    alu_op_e     alu_op;
    insn_class_e cls;

    assign insn      = imem_data;
    assign imem_addr = pc_q;
    assign pc_inc    = pc_q + 1'b1;
    assign cls       = insn_class_e'(insn[14:13]);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            pc_q    <= '0;
            tos_q   <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            tos_q   <= tos_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // execute controls
    always_comb begin
        pc_d     = pc_q;
        tos_d    = tos_q;
        ds_delta = 2'b00;
        ds_we    = 1'b0;
        rs_delta = 2'b00;
        rs_we    = 1'b0;
        rs_wdata = tos_q;
        st_en    = 1'b0;
        alu_op   = OP_T;
        unique case (state_q)
            ST_BOOT: ;
            ST_RUN: begin
                pc_d = pc_inc;
                if (insn[15]) begin
                    tos_d    = {1'b0, insn[14:0]};
                    ds_delta = 2'b01;
                    ds_we    = 1'b1;
                end else begin
                    unique case (cls)
                        CL_JUMP: pc_d = insn[12:0];
                        CL_CJUMP: begin
                            tos_d    = nos;
                            ds_delta = 2'b11;
                            if (tos_q == '0) pc_d = insn[12:0];
                        end
                        CL_CALL: begin
                            rs_delta = 2'b01;
                            rs_we    = 1'b1;
                            rs_wdata = {2'b00, pc_inc, 1'b0};
                            pc_d     = insn[12:0];
                        end
                        CL_ALU: begin
                            alu_op   = alu_op_e'(insn[11:8]);
                            tos_d    = alu_res;
                            ds_we    = insn[7];
                            rs_we    = insn[6];
                            st_en    = insn[5];
                            rs_delta = insn[3:2];
                            ds_delta = insn[1:0];
                            if (insn[12]) pc_d = rtop[PC_W:1];
                        end
                    endcase
                end
            end
        endcase
    end

    stk16_stack #(.W(WORD_W), .DEPTH(DS_DEPTH)) u_dstack (
        .clk(clk), .rst_n(rst_n), .delta(ds_delta), .we(ds_we),
        .wdata(tos_q), .top(nos), .ptr(ds_ptr)
    );

    stk16_stack #(.W(WORD_W), .DEPTH(RS_DEPTH)) u_rstack (
        .clk(clk), .rst_n(rst_n), .delta(rs_delta), .we(rs_we),
        .wdata(rs_wdata), .top(rtop), .ptr(rs_ptr)
    );

    stk16_alu u_alu (
        .op(alu_op), .t(tos_q), .n(nos), .r(rtop), .mem_rd(mem_rd),
        .depth(word_t'(ds_ptr)), .res(alu_res)
    );

    // data port decode
    assign sel_io    = tos_q[14];
    assign ram_addr  = tos_q[13:1];
    assign io_addr   = tos_q[13:1];
    assign ram_wdata = nos;
    assign io_wdata  = nos;
    assign ram_we    = st_en & ~sel_io;
    assign io_we     = st_en & sel_io;
    assign mem_rd    = sel_io ? io_rdata : ram_rdata;

    AST_BOOT_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BOOT |-> imem_addr == '0); // R1
    AST_LIT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && insn[15]) |=>
            (tos_q == {1'b0, $past(insn[14:0])}) && (ds_ptr == DPW'($past(ds_ptr) + 1'b1))); // R2
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && insn[15:13] == 3'b000) |=> imem_addr == $past(insn[12:0])); // R3
    AST_CJUMP_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && insn[15:13] == 3'b001) |=> ds_ptr == DPW'($past(ds_ptr) - 1'b1)); // R4
    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && insn[15:13] == 3'b010) |=>
            rtop == {2'b00, PC_W'($past(pc_q) + 1'b1), 1'b0}); // R5

endmodule

// File: tb/tb_stk16_core.sv
module tb_stk16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] imem_addr, ram_addr, io_addr;
    logic [15:0] imem_data, ram_wdata, ram_rdata, io_wdata, io_rdata;
    logic        ram_we, io_we;

    logic [15:0] imem [256];
    logic [15:0] ram_m [256];
    logic [15:0] io_last;
    logic [12:0] io_last_addr;
    int          io_cnt;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    stk16_core dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    assign imem_data = imem[imem_addr[7:0]];
    assign ram_rdata = ram_m[ram_addr[7:0]];
    assign io_rdata  = 16'h5A5A;

    always @(posedge clk) begin
        if (!rst_n) begin
            io_cnt <= 0; io_last <= '0; io_last_addr <= '0;
        end else begin
            if (io_we) begin
                io_cnt <= io_cnt + 1; io_last <= io_wdata; io_last_addr <= io_addr;
            end
            if (ram_we) ram_m[ram_addr[7:0]] <= ram_wdata;
        end
    end

    // {N, T, op, expected}
    localparam logic [51:0] VEC [15] = '{
        52'h0000_7FFF_0_7FFF, 52'h1111_2222_1_1111, 52'h1234_0F0F_2_2143,
        52'h0FF0_3C3C_3_0C30, 52'h0F00_00F0_4_0FF0, 52'h5555_7FFF_5_2AAA,
        52'h1111_00FF_6_FF00, 52'h0055_0055_7_FFFF, 52'h0055_0056_7_0000,
        52'h0003_0005_8_FFFF, 52'h0005_0003_F_0000, 52'h0F00_0004_9_00F0,
        52'h0F00_0004_D_F000, 52'h1234_0000_A_FFFF, 52'h7000_0001_2_7001
    };

    function automatic logic [15:0] f_lit(logic [14:0] v); return {1'b1, v}; endfunction
    function automatic logic [15:0] f_jmp(logic [12:0] a); return {3'b000, a}; endfunction
    function automatic logic [15:0] f_cj(logic [12:0] a);  return {3'b001, a}; endfunction
    function automatic logic [15:0] f_call(logic [12:0] a); return {3'b010, a}; endfunction
    function automatic logic [15:0] f_alu(logic rpc, logic [3:0] op, logic tn, logic tr,
                                          logic st, logic [1:0] rd, logic [1:0] dd);
        return {3'b011, rpc, op, tn, tr, st, 1'b0, rd, dd};
    endfunction
    function automatic logic [15:0] f_store(); return f_alu(0, 4'd1, 0, 0, 1, 2'b00, 2'b11); endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clr_prog();
        for (int i = 0; i < 256; i++) imem[i] = f_jmp(13'(i));
    endtask

    task automatic run_prog(int cyc);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (cyc) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=0", 1);
        finish_up();
    end

    initial begin
        logic [15:0] vn, vt, ve;
        logic [3:0]  vop;
        string       rq;

        // ALU table
        for (int i = 0; i < 15; i++) begin
            vn = VEC[i][51:36]; vt = VEC[i][35:20]; vop = VEC[i][19:16]; ve = VEC[i][15:0];
            rq = (vop == 4'd7 || vop == 4'd8 || vop == 4'd15) ? "R8" :
                 (vop == 4'd9 || vop == 4'd13) ? "R9" : "R7";
            clr_prog();
            imem[0] = f_lit(vn[14:0]); imem[1] = f_lit(vt[14:0]);
            imem[2] = f_alu(0, vop, 0, 0, 0, 2'b00, 2'b11);
            imem[3] = f_lit(15'h4000); imem[4] = f_store();
            run_prog(12);
            chk(rq, io_last, ve);
        end

        // R1 reset and boot cycle, R3 jump
        clr_prog(); imem[0] = f_jmp(13'd7);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R1", 16'(imem_addr), 16'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", 16'(imem_addr), 16'd0);
        @(posedge clk); @(negedge clk);
        chk("R3", 16'(imem_addr), 16'd7);

        // R4 conditional jump, taken and not taken
        for (int z = 0; z < 2; z++) begin
            clr_prog();
            imem[0] = f_lit(15'd5); imem[1] = f_lit(z == 0 ? 15'd0 : 15'd9);
            imem[2] = f_cj(13'd6); imem[3] = f_lit(15'h4000); imem[4] = f_store();
            imem[6] = f_lit(15'h4002); imem[7] = f_store();
            run_prog(12);
            chk("R4", 16'(io_last_addr), z == 0 ? 16'd1 : 16'd0);
            chk("R4", io_last, 16'd5);
        end

        // R5 call link read by R10 return-top op, then return via bit 12
        clr_prog();
        imem[0] = f_call(13'd4); imem[1] = f_lit(15'h4000); imem[2] = f_store();
        imem[4] = f_alu(0, 4'd11, 1, 0, 0, 2'b00, 2'b01);
        imem[5] = f_alu(1, 4'd0, 0, 0, 0, 2'b11, 2'b00);
        run_prog(12);
        chk("R5", io_last, 16'd2);
        chk("R10", 16'(io_cnt), 16'd1);

        // R6 move to return stack and back
        clr_prog();
        imem[0] = f_lit(15'h55);
        imem[1] = f_alu(0, 4'd1, 0, 1, 0, 2'b01, 2'b11);
        imem[2] = f_alu(0, 4'd11, 1, 0, 0, 2'b11, 2'b01);
        imem[3] = f_lit(15'h4000); imem[4] = f_store();
        run_prog(12);
        chk("R6", io_last, 16'h0055);

        // R11 RAM store and R10 load, routing
        clr_prog();
        imem[0] = f_lit(15'h99); imem[1] = f_lit(15'h10); imem[2] = f_store();
        imem[3] = f_lit(15'h10); imem[4] = f_alu(0, 4'd12, 0, 0, 0, 2'b00, 2'b00);
        imem[5] = f_lit(15'h4006); imem[6] = f_store();
        run_prog(14);
        chk("R11", ram_m[8], 16'h0099);
        chk("R10", io_last, 16'h0099);
        chk("R11", 16'(io_cnt), 16'd1);
        chk("R11", 16'(io_last_addr), 16'd3);

        // R10 load from I/O space
        clr_prog();
        imem[0] = f_lit(15'h4000); imem[1] = f_alu(0, 4'd12, 0, 0, 0, 2'b00, 2'b00);
        imem[2] = f_lit(15'h4000); imem[3] = f_store();
        run_prog(10);
        chk("R10", io_last, 16'h5A5A);

        // R10 depth after three pushes
        clr_prog();
        imem[0] = f_lit(15'd1); imem[1] = f_lit(15'd2); imem[2] = f_lit(15'd3);
        imem[3] = f_alu(0, 4'd14, 1, 0, 0, 2'b00, 2'b01);
        imem[4] = f_lit(15'h4000); imem[5] = f_store();
        run_prog(12);
        chk("R10", io_last, 16'd3);

        // R12 drop two at once
        imem[3] = f_alu(0, 4'd0, 0, 0, 0, 2'b00, 2'b10);
        imem[4] = f_alu(0, 4'd14, 1, 0, 0, 2'b00, 2'b01);
        imem[5] = f_lit(15'h4000); imem[6] = f_store();
        run_prog(14);
        chk("R12", io_last, 16'd1);

        // R8 signed versus unsigned on a negative operand
        for (int u = 0; u < 2; u++) begin
            clr_prog();
            imem[0] = f_lit(15'd0); imem[1] = f_alu(0, 4'd6, 0, 0, 0, 2'b00, 2'b00);
            imem[2] = f_lit(15'd1);
            imem[3] = f_alu(0, u == 0 ? 4'd8 : 4'd15, 0, 0, 0, 2'b00, 2'b11);
            imem[4] = f_lit(15'h4000); imem[5] = f_store();
            run_prog(12);
            chk("R8", io_last, u == 0 ? 16'hFFFF : 16'h0000);
        end

        // R2 literal keeps pushed items, read back after a pop
        clr_prog();
        imem[0] = f_lit(15'h7ABC); imem[1] = f_lit(15'h0001);
        imem[2] = f_alu(0, 4'd1, 0, 0, 0, 2'b00, 2'b11);
        imem[3] = f_lit(15'h4000); imem[4] = f_store();
        run_prog(12);
        chk("R2", io_last, 16'h7ABC);

        finish_up();
    end
endmodule